// File: doc/BRIEF.md
# Banked GPIO Controller with Masked Half-Word Writes

This block is a memory-mapped general-purpose I/O controller with four banks of 32 pin positions. Each bank holds an output data latch, a direction register and an output-enable register. It drives the pad output levels and the per-pin tristate enables. Pad inputs pass through a two-flop synchronizer and can be read from a read-only register for each bank.

Software can also change output bits through half-bank masked write registers. These update any chosen subset of 16 output bits in a single bus write, with no read-modify-write. Pin positions 54 to 63 do not exist, so bank 1 has only bits 21:0. Nonexistent positions read as zero, ignore writes and never drive.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, every readable register reads zero, and pad_oe_o and pad_out_o are all zero.
- R2: A write to the output data register at byte offset 0x40+4*b stores the word in bank b. Reading that offset returns the stored latch, not the pad level.
- R3: A write to offset 8*b updates the low half of bank b's output latch. Bits [31:16] of the write are a keep mask and bits [15:0] are the new data. A mask bit of 0 loads the data bit. A mask bit of 1 keeps the old value. Bits 31:16 of the latch do not change.
- R4: A write to offset 8*b+4 updates bits 31:16 of bank b's output latch under the same mask rule. Bits 15:0 of the latch do not change.
- R5: The direction register is at 0x204+0x40*b and the output-enable register is at 0x208+0x40*b. Both read back what was written.
- R6: Pin 32*b+i drives only when both direction bit i and output-enable bit i of bank b are 1. pad_out_o carries the output latch whatever the direction.
- R7: Offset 0x60+4*b returns bank b's pad inputs after two synchronizing flops. Writes to this offset have no effect.
- R8: Read data appears on rdata_o in the cycle after rd_en_i and is zero in every other cycle. The following all read as zero: unmapped offsets, offsets that are not word aligned, and the masked write registers.
- R9: Nonexistent positions (pins 54..63, which are bank 1 bits 31:22) read as zero in every register, ignore writes and keep pad_oe_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| rd_en_i | input | 1 | Read strobe; data returns one cycle later |
| addr_i | input | 12 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, zero when no read is returning |
| pad_in_i | input | 128 | Pad input levels, pin n at bit n |
| pad_out_o | output | 128 | Pad output levels (the output latches) |
| pad_oe_o | output | 128 | Pad driver enables |

## Verification
A corrupted output latch, direction bit or enable bit appears combinationally on pad_out_o or pad_oe_o right after the faulty write. It also appears on rdata_o one cycle after a read of that register. A wrong mask polarity or a wrong half selection leaves bits that differ from the arithmetic model after a single masked write. For that reason, every masked write is followed at once by a read-back. A broken synchronizer depth or a broken populated-bit mask shows in the input register three cycles after the pad changes.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_MASK_LO,
    ACC_MASK_HI,
    ACC_DATA,
    ACC_INPUT,
    ACC_DIR,
    ACC_OEN
  } acc_kind_e;

  // populated bits of one bank: pins [0, grp0_n) and [grp1_base, total)
  function automatic logic [31:0] pop_mask(input int bank, input int bank_w,
                                           input int grp0_n, input int grp1_base);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < bank_w; i++) begin
      int pin;
      pin = bank * bank_w + i;
      m[i] = (pin < grp0_n) || (pin >= grp1_base);
    end
    return m;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;

  // R7
  sync_pipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_q == $past(s1_q));
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned MASK_BASE = 'h000,
  parameter int unsigned DATA_BASE = 'h040,
  parameter int unsigned IN_BASE   = 'h060,
  parameter int unsigned DIR_BASE  = 'h204,
  parameter int unsigned OEN_BASE  = 'h208,
  parameter int unsigned CTL_STEP  = 'h040
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output acc_kind_e            kind_o,
  output logic [NUM_BANKS-1:0] bank_hit_o
);
  always_comb begin
    kind_o     = ACC_NONE;
    bank_hit_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr_i == ADDR_W'(MASK_BASE + 8*b)) begin
        kind_o = ACC_MASK_LO; bank_hit_o[b] = 1'b1;
      end
      if (addr_i == ADDR_W'(MASK_BASE + 8*b + 4)) begin
        kind_o = ACC_MASK_HI; bank_hit_o[b] = 1'b1;
      end
      if (addr_i == ADDR_W'(DATA_BASE + 4*b)) begin
        kind_o = ACC_DATA; bank_hit_o[b] = 1'b1;
      end
      if (addr_i == ADDR_W'(IN_BASE + 4*b)) begin
        kind_o = ACC_INPUT; bank_hit_o[b] = 1'b1;
      end
      if (addr_i == ADDR_W'(DIR_BASE + CTL_STEP*b)) begin
        kind_o = ACC_DIR; bank_hit_o[b] = 1'b1;
      end
      if (addr_i == ADDR_W'(OEN_BASE + CTL_STEP*b)) begin
        kind_o = ACC_OEN; bank_hit_o[b] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned W   = 32,
  parameter logic [W-1:0] POP = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic         hit_i,
  input  acc_kind_e    kind_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] sync_in_i,
  output logic [W-1:0] rd_word_o,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_oe_o
);
  localparam int unsigned HALF = W / 2;

  logic [W-1:0]    data_q, dir_q, oen_q, data_d;
  logic [HALF-1:0] keep, newv;
  logic            wr_hit;

  assign wr_hit = wr_en_i && hit_i;
  assign keep   = wdata_i[W-1:HALF];
  assign newv   = wdata_i[HALF-1:0];

  always_comb begin
    data_d = data_q;
    if (wr_hit) begin
      unique case (kind_i)
        ACC_DATA:    data_d = wdata_i;
        ACC_MASK_LO: data_d[HALF-1:0] = (data_q[HALF-1:0] & keep) | (newv & ~keep);
        ACC_MASK_HI: data_d[W-1:HALF] = (data_q[W-1:HALF] & keep) | (newv & ~keep);
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '0;
      oen_q  <= '0;
    end else begin
      data_q <= data_d & POP;
      if (wr_hit && kind_i == ACC_DIR) dir_q <= wdata_i & POP;
      if (wr_hit && kind_i == ACC_OEN) oen_q <= wdata_i & POP;
    end
  end

  always_comb begin
    rd_word_o = '0;
    if (hit_i) begin
      unique case (kind_i)
        ACC_DATA:  rd_word_o = data_q;
        ACC_INPUT: rd_word_o = sync_in_i & POP;
        ACC_DIR:   rd_word_o = dir_q;
        ACC_OEN:   rd_word_o = oen_q;
        default:   rd_word_o = '0;
      endcase
    end
  end

  assign pad_out_o = data_q;
  assign pad_oe_o  = dir_q & oen_q;

  // R3
  mask_lo_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && kind_i == ACC_MASK_LO) |=>
      ((data_q[HALF-1:0] & $past(keep)) == ($past(data_q[HALF-1:0]) & $past(keep)))
      && (data_q[W-1:HALF] == $past(data_q[W-1:HALF])));
  // R4
  mask_hi_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && kind_i == ACC_MASK_HI) |=>
      ((data_q[W-1:HALF] & $past(keep)) == ($past(data_q[W-1:HALF]) & $past(keep)))
      && (data_q[HALF-1:0] == $past(data_q[HALF-1:0])));
  // R9
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit |=> $stable(data_q) && $stable(dir_q) && $stable(oen_q));
  // R9
  unpop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o | pad_out_o) & ~POP) == '0);
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned GRP0_PINS = 54,
  parameter int unsigned GRP1_BASE = 64,
  localparam int unsigned PINS     = NUM_BANKS * BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] rdata_o,
  input  logic [PINS-1:0]   pad_in_i,
  output logic [PINS-1:0]   pad_out_o,
  output logic [PINS-1:0]   pad_oe_o
);
  acc_kind_e             kind;
  logic [NUM_BANKS-1:0]  bank_hit;
  logic [PINS-1:0]       sync_in;
  logic [BANK_W-1:0]     rd_word [NUM_BANKS];
  logic [BANK_W-1:0]     rd_mux, rdata_q;

  gpio_addr_dec #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) i_dec (
    .addr_i     (addr_i),
    .kind_o     (kind),
    .bank_hit_o (bank_hit)
  );

  gpio_sync #(.W(PINS)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (sync_in)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [BANK_W-1:0] POP_B =
      BANK_W'(pop_mask(b, BANK_W, GRP0_PINS, GRP1_BASE));
    gpio_bank #(.W(BANK_W), .POP(POP_B)) i_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .hit_i     (bank_hit[b]),
      .kind_i    (kind),
      .wdata_i   (wdata_i),
      .sync_in_i (sync_in[b*BANK_W +: BANK_W]),
      .rd_word_o (rd_word[b]),
      .pad_out_o (pad_out_o[b*BANK_W +: BANK_W]),
      .pad_oe_o  (pad_oe_o[b*BANK_W +: BANK_W])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) rd_mux |= rd_word[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
    else              rdata_q <= '0;
  end

  assign rdata_o = rdata_q;

  // R8
  rd_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> rdata_o == '0);
  // R8
  one_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_hit));
endmodule

// File: tb/test_gpio_ctrl.sv
`timescale 1ns/1ps
module test_gpio_ctrl;
  localparam int NB = 4;
  localparam int BW = 32;
  localparam int NP = NB * BW;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          wr_en = 0, rd_en = 0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_data [NB];
  logic [31:0] m_dir  [NB];
  logic [31:0] m_oen  [NB];
  logic [31:0] pop    [NB];

  always #2 clk = ~clk;

  gpio_ctrl i_gpio_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; addr = '0;
    d = rdata;
  endtask

  task automatic chk_pads(input string req);
    for (int b = 0; b < NB; b++) begin
      chk({req, " oe"},  pad_oe[b*BW +: BW],  m_dir[b] & m_oen[b]);
      chk({req, " out"}, pad_out[b*BW +: BW], m_data[b]);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] pats [6];
    pats = '{32'hFFFF_FFFF, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'h1234_5678,
             32'h8000_0001, 32'h0000_0000};
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < BW; i++) begin
        int pin;
        pin = b * BW + i;
        pop[b][i] = (pin < 54) || (pin >= 64);
      end
      m_data[b] = '0; m_dir[b] = '0; m_oen[b] = '0;
    end

    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk_pads("R1");
    for (int b = 0; b < NB; b++) begin
      rd(12'h040 + 12'(4*b), d);         chk("R1 data", d, 0);
      rd(12'h204 + 12'(64*b), d);        chk("R1 dir", d, 0);
      rd(12'h208 + 12'(64*b), d);        chk("R1 oen", d, 0);
    end

    // R2 / R9 direct data writes
    for (int b = 0; b < NB; b++)
      for (int p = 0; p < 6; p++) begin
        wr(12'h040 + 12'(4*b), pats[p]);
        m_data[b] = pats[p] & pop[b];
        rd(12'h040 + 12'(4*b), d);
        chk("R2/R9 data", d, m_data[b]);
        chk("R2 pad_out", pad_out[b*BW +: BW], m_data[b]);
      end

    // R3 / R4 masked half writes
    for (int b = 0; b < NB; b++)
      for (int h = 0; h < 2; h++) begin
        wr(12'h040 + 12'(4*b), 32'hC3C3_3C3C);
        m_data[b] = 32'hC3C3_3C3C & pop[b];
        for (int p = 0; p < 6; p++) begin
          logic [15:0] km, nv;
          logic [31:0] w;
          km = pats[p][31:16] ^ 16'h0F0F;
          nv = pats[(p + 1) % 6][15:0] ^ 16'hFFFF;
          w  = {km, nv};
          wr(12'(8*b + 4*h), w);
          if (h == 0) m_data[b][15:0]  = (m_data[b][15:0]  & km) | (nv & ~km);
          else        m_data[b][31:16] = (m_data[b][31:16] & km) | (nv & ~km);
          m_data[b] &= pop[b];
          rd(12'h040 + 12'(4*b), d);
          chk(h == 0 ? "R3 mask lo" : "R4 mask hi", d, m_data[b]);
        end
      end

    // R5 / R6 / R9 direction and enable
    for (int p = 0; p < 6; p++) begin
      for (int b = 0; b < NB; b++) begin
        wr(12'h204 + 12'(64*b), pats[p]);
        wr(12'h208 + 12'(64*b), pats[(p + b) % 6]);
        m_dir[b] = pats[p] & pop[b];
        m_oen[b] = pats[(p + b) % 6] & pop[b];
        rd(12'h204 + 12'(64*b), d); chk("R5 dir", d, m_dir[b]);
        rd(12'h208 + 12'(64*b), d); chk("R5 oen", d, m_oen[b]);
      end
      chk_pads("R6/R9");
    end

    // R7 synchronized inputs, writes ignored
    for (int p = 0; p < 6; p++) begin
      @(negedge clk);
      for (int b = 0; b < NB; b++) pad_in[b*BW +: BW] = pats[(p + b) % 6];
      repeat (3) @(negedge clk);
      for (int b = 0; b < NB; b++) begin
        wr(12'h060 + 12'(4*b), ~pats[p]);
        rd(12'h060 + 12'(4*b), d);
        chk("R7 input", d, pats[(p + b) % 6] & pop[b]);
      end
      chk_pads("R7 no side effect");
    end
    // R7 two-flop delay: change pad, read at once sees old value
    @(negedge clk);
    pad_in[31:0] = 32'h0000_FFFF;
    rd(12'h060, d);
    chk("R7 sync delay", d, pats[5]);
    repeat (2) @(negedge clk);
    rd(12'h060, d);
    chk("R7 sync settle", d, 32'h0000_FFFF);

    // R8 latency, unmapped, unaligned, masked reads
    wr(12'h040, 32'hDEAD_BEEF);
    m_data[0] = 32'hDEAD_BEEF;
    rd(12'h040, d); chk("R8 read", d, 32'hDEAD_BEEF);
    @(negedge clk); chk("R8 idle zero", rdata, 0);
    rd(12'h000, d); chk("R8 masked reads 0", d, 0);
    rd(12'h00C, d); chk("R8 masked reads 0", d, 0);
    rd(12'h042, d); chk("R8 unaligned", d, 0);
    rd(12'h080, d); chk("R8 unmapped", d, 0);
    rd(12'h200, d); chk("R8 unmapped", d, 0);
    rd(12'h2D0, d); chk("R8 unmapped", d, 0);
    wr(12'h100, 32'hFFFF_FFFF);
    chk_pads("R8 unmapped write");

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule